// File: doc/BRIEF.md
# Clock-Stop Serial Port in SPI Role

This block is a serial port that runs as either end of an SPI link in a clock-stop fashion. The serial clock moves only while a packet is shifted. The frame-sync output acts as an active-low slave select. It stays low for the whole packet and goes high again after every packet, including when more words are already waiting. As a master, the block generates the bit clock from the system clock with a programmable half-period. As a slave, it brings the external clock, select and data in through a synchronizer and works on the edges it detects in the system clock domain.

A word to send is offered on a valid/ready pair. A received word appears on a parallel output together with a one-cycle strobe. One length setting serves both directions, because a single clock moves both shift paths. A 2-bit phase field selects either immediate clocking or clocking delayed by half a bit. A polarity bit sets the level the clock rests at. The role input decides which pins carry the transmit and receive data.

Top module: `csspi_port`

## Requirements
- R1: `cfg_len` selects the packet length used by both directions: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24 and 5 gives 32. The codes 6 and 7 give 8 bits.
- R2: Data moves most-significant bit first. For a length of N, only `tx_data[N-1:0]` is sent and the higher bits are ignored. The received word is right-aligned in `rx_data[N-1:0]` with every higher bit zero.
- R3: As master, `ss_n_o` is low for exactly 2·N·H system cycles per packet. During that time `sck_o` makes exactly 2·N transitions. Whenever `ss_n_o` is high, `sck_o` rests at `cfg_pol`.
- R4: As master, after each packet `ss_n_o` stays high for at least 4·H system cycles (two bit periods), even when `tx_valid` is held high back to back. `tx_ready` is low during that gap.
- R5: `cfg_mode` = 2'b10 (no delay): the first clock edge comes together with the select falling and the first data bit. Data is sampled on each edge that returns the clock to `cfg_pol`. `cfg_mode` = 2'b11 (delay): the first edge comes H cycles after the select falls, and data is sampled on each edge that leaves `cfg_pol`. Any mode with bit 1 clear disables the port, and `tx_ready` stays low.
- R6: As master, one bit period is 2·H system cycles, where H is `cfg_half`. A value of 0 counts as 1.
- R7: As master (`cfg_master`=1), transmit data leaves on `mosi_o`, receive data is taken from `miso_i`, and `miso_o` is 0. As slave, transmit data leaves on `miso_o`, receive data is taken from `mosi_i`, `mosi_o` is 0 and `ss_n_o` is 1.
- R8: As slave, a word accepted while idle is presented MSB first from the select falling. If no word was accepted, the slave sends all zeros.
- R9: After reset `rx_valid` is 0 and `ss_n_o` is 1. `rx_valid` is a single-cycle pulse after the last bit of a packet is sampled. `tx_ready` is high only when the port is idle.
- R10: As slave, if the select rises before N bits have been sampled, the packet is dropped without a `rx_valid` pulse. The next packet then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_mode | input | 2 | Phase field: 10 = no delay, 11 = half-bit delay, 0x = disabled |
| cfg_len | input | 3 | Packet length code |
| cfg_pol | input | 1 | Resting level of the serial clock |
| cfg_half | input | DIV_W | Master half-bit period in system cycles |
| tx_data | input | MAX_BITS | Word to send, right-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word accepted this cycle if valid |
| rx_data | output | MAX_BITS | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| sck_o | output | 1 | Serial clock output (master) |
| ss_n_o | output | 1 | Active-low select output (master) |
| mosi_o | output | 1 | Master-out data pin |
| miso_i | input | 1 | Master-in data pin |
| sck_i | input | 1 | Serial clock input (slave) |
| ss_n_i | input | 1 | Active-low select input (slave) |
| mosi_i | input | 1 | Slave-in data pin |
| miso_o | output | 1 | Slave-out data pin |

## Verification
The in-RTL properties watch, on every cycle, that the clock rests at its idle level while the select is high. They also check the minimum deselect gap between master packets, measured against the half-period latched at the end of each packet. The remaining per-cycle properties cover the single-cycle receive strobe, the zero fill above the packet length, the quiet pins of the unused role and the absence of ready while disabled. Only the bench scenarios can show that the data is correct bit for bit, and that the two phase modes place the first edge and the sampling edge where R5 says. They also show the slave behaviour: the preloaded word, zero output when nothing was loaded, and a clean abort.

// File: rtl/csspi_pkg.sv
package csspi_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARMED,
      ST_SHIFT,
      ST_GAP,
      ST_HOLD
   } csspi_state_t;

   // Packet length in bits for a length code; unsupported codes fall back to 8.
   function automatic logic [5:0] len_bits(input logic [2:0] code);
      logic [5:0] n;
      unique case (code)
         3'd0:    n = 6'd8;
         3'd1:    n = 6'd12;
         3'd2:    n = 6'd16;
         3'd3:    n = 6'd20;
         3'd4:    n = 6'd24;
         3'd5:    n = 6'd32;
         default: n = 6'd8;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/csspi_halftick.sv
module csspi_halftick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] eff;

   assign eff  = (half_div == '0) ? DIV_W'(1) : half_div;
   assign tick = run && (cnt == eff - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/csspi_sync.sv
module csspi_sync #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   logic [W-1:0] chain [STAGES+1];

   generate
      if (STAGES < 2) begin : g_bad
         $error("csspi_sync needs at least two stages");
      end
      for (genvar s = 0; s <= STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain[s] <= RST_VAL;
            else if (s == 0)
               chain[s] <= d;
            else
               chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q      = chain[STAGES-1];
   assign q_prev = chain[STAGES];
endmodule

// File: rtl/csspi_shreg.sv
module csspi_shreg #(
   parameter int MAX_BITS = 32,
   parameter int NBW      = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NBW-1:0]      nbits,
   input  logic                tx_load,
   input  logic [MAX_BITS-1:0] tx_word,
   input  logic                tx_shift,
   input  logic                tx_clr,
   output logic                tx_msb,
   input  logic                rx_clr,
   input  logic                rx_shift,
   input  logic                rx_bit,
   output logic [MAX_BITS-1:0] rx_word
);
   logic [MAX_BITS-1:0] txsh;
   logic [MAX_BITS-1:0] rxsh;
   logic [NBW-1:0]      pad;

   // Left-justify the active bits so the packet MSB sits at the top.
   assign pad    = NBW'(MAX_BITS) - nbits;
   assign tx_msb = txsh[MAX_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         txsh <= '0;
      else if (tx_load)
         txsh <= tx_word << pad;
      else if (tx_clr)
         txsh <= '0;
      else if (tx_shift)
         txsh <= {txsh[MAX_BITS-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rxsh <= '0;
      else if (rx_clr)
         rxsh <= '0;
      else if (rx_shift)
         rxsh <= {rxsh[MAX_BITS-2:0], rx_bit};
   end

   assign rx_word = rxsh;
endmodule

// File: rtl/csspi_port.sv
module csspi_port
   import csspi_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int MAX_BITS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_master,
   input  logic [1:0]          cfg_mode,
   input  logic [2:0]          cfg_len,
   input  logic                cfg_pol,
   input  logic [DIV_W-1:0]    cfg_half,
   input  logic [MAX_BITS-1:0] tx_data,
   input  logic                tx_valid,
   output logic                tx_ready,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                rx_valid,
   output logic                sck_o,
   output logic                ss_n_o,
   output logic                mosi_o,
   input  logic                miso_i,
   input  logic                sck_i,
   input  logic                ss_n_i,
   input  logic                mosi_i,
   output logic                miso_o
);
   localparam int NBW = $clog2(MAX_BITS + 1);
   localparam int HIW = $clog2(2 * MAX_BITS);
   localparam int GW  = DIV_W + 2;

   generate
      if (MAX_BITS < 32) begin : g_chk_bits
         $error("MAX_BITS must hold the longest packet (32)");
      end
      if (DIV_W < 1) begin : g_chk_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   csspi_state_t   state;
   logic [HIW-1:0] hidx;
   logic [NBW-1:0] scnt;
   logic [GW-1:0]  gcnt;
   logic           armed;

   logic [NBW-1:0]   nbits;
   logic [HIW-1:0]   last_h;
   logic [NBW-1:0]   last_b;
   logic [DIV_W-1:0] eff;
   logic [GW-1:0]    gap_last;
   logic             enabled, nodelay;

   assign nbits    = NBW'(len_bits(cfg_len));
   assign last_h   = HIW'({nbits, 1'b0}) - HIW'(1);
   assign last_b   = nbits - NBW'(1);
   assign eff      = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
   assign gap_last = {eff, 2'b00} - GW'(1);
   assign enabled  = cfg_mode[1];
   assign nodelay  = ~cfg_mode[0];

   // Slave-side pin synchronizer: {sck, ss_n, mosi}
   logic [2:0] s_now, s_prev;
   csspi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      ({sck_i, ss_n_i, mosi_i}),
      .q      (s_now),
      .q_prev (s_prev)
   );

   logic into_idle, out_idle, sample_e, launch_e, ss_fall, ss_rise;
   assign into_idle = (s_now[2] == cfg_pol) && (s_prev[2] != cfg_pol);
   assign out_idle  = (s_now[2] != cfg_pol) && (s_prev[2] == cfg_pol);
   assign sample_e  = nodelay ? into_idle : out_idle;
   assign launch_e  = nodelay ? out_idle  : into_idle;
   assign ss_fall   = s_prev[1] && !s_now[1];
   assign ss_rise   = !s_prev[1] && s_now[1];

   // Master half-bit timer
   logic m_run, tick;
   assign m_run = cfg_master && (state == ST_SHIFT);
   csspi_halftick #(.DIV_W(DIV_W)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (m_run),
      .half_div (cfg_half),
      .tick     (tick)
   );

   logic tx_fire, go_slave, s_run;
   assign tx_ready = enabled && (state == ST_IDLE) && (cfg_master || s_now[1]);
   assign tx_fire  = tx_valid && tx_ready;
   assign go_slave = !cfg_master && enabled && ss_fall &&
                     ((state == ST_IDLE) || (state == ST_ARMED));
   assign s_run    = !cfg_master && (state == ST_SHIFT) && !ss_rise;

   logic tx_shift, tx_clr, rx_shift, rx_clr, rx_bit, tx_msb;
   assign tx_shift = (m_run && tick && hidx[0] && (hidx != last_h)) ||
                     (s_run && launch_e && armed);
   assign tx_clr   = !cfg_master && ss_rise &&
                     ((state == ST_SHIFT) || (state == ST_HOLD));
   assign rx_shift = (m_run && tick && !hidx[0]) || (s_run && sample_e);
   assign rx_clr   = (tx_fire && cfg_master) || go_slave;
   assign rx_bit   = cfg_master ? miso_i : s_now[0];

   csspi_shreg #(.MAX_BITS(MAX_BITS), .NBW(NBW)) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .nbits    (nbits),
      .tx_load  (tx_fire),
      .tx_word  (tx_data),
      .tx_shift (tx_shift),
      .tx_clr   (tx_clr),
      .tx_msb   (tx_msb),
      .rx_clr   (rx_clr),
      .rx_shift (rx_shift),
      .rx_bit   (rx_bit),
      .rx_word  (rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         hidx     <= '0;
         scnt     <= '0;
         gcnt     <= '0;
         armed    <= 1'b0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (tx_fire) begin
                  state <= cfg_master ? ST_SHIFT : ST_ARMED;
                  hidx  <= '0;
               end else if (go_slave) begin
                  state <= ST_SHIFT;
                  scnt  <= '0;
                  armed <= 1'b0;
               end
            end
            ST_ARMED: begin
               if (go_slave) begin
                  state <= ST_SHIFT;
                  scnt  <= '0;
                  armed <= 1'b0;
               end else if (!enabled) begin
                  state <= ST_IDLE;
               end
            end
            ST_SHIFT: begin
               if (cfg_master) begin
                  if (tick) begin
                     if (hidx == last_h) begin
                        state    <= ST_GAP;
                        gcnt     <= '0;
                        rx_valid <= 1'b1;
                     end else begin
                        hidx <= hidx + HIW'(1);
                     end
                  end
               end else if (ss_rise) begin
                  state <= ST_IDLE;
               end else if (sample_e) begin
                  armed <= 1'b1;
                  if (scnt == last_b) begin
                     state    <= ST_HOLD;
                     rx_valid <= 1'b1;
                  end else begin
                     scnt <= scnt + NBW'(1);
                  end
               end else if (launch_e) begin
                  armed <= 1'b0;
               end
            end
            ST_GAP: begin
               if (gcnt == gap_last)
                  state <= ST_IDLE;
               else
                  gcnt <= gcnt + GW'(1);
            end
            ST_HOLD: begin
               if (ss_rise)
                  state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Pin drive: no-delay mode leaves idle in the first half, delay mode in the second.
   assign sck_o  = m_run ? (cfg_pol ^ (nodelay ? ~hidx[0] : hidx[0])) : cfg_pol;
   assign ss_n_o = ~m_run;
   assign mosi_o = m_run ? tx_msb : 1'b0;
   assign miso_o = (!cfg_master && ((state == ST_SHIFT) || (state == ST_HOLD))) ? tx_msb : 1'b0;

   // ---------------- assertions ----------------
   logic [15:0]   hi_cnt;
   logic [GW-1:0] gap_need;
   logic          pkt_seen;
   logic          ss_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= '0;
         gap_need <= '0;
         pkt_seen <= 1'b0;
         ss_q     <= 1'b1;
      end else begin
         ss_q <= ss_n_o;
         if (ss_n_o)
            hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1;
         else
            hi_cnt <= '0;
         if (ss_n_o && !ss_q) begin
            pkt_seen <= 1'b1;
            gap_need <= {eff, 2'b00};
         end
      end
   end

   p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && pkt_seen && ss_q && !ss_n_o) |-> (hi_cnt >= 16'(gap_need)));

   p_clk_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && ss_n_o) |-> (sck_o == cfg_pol));

   p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ((rx_data >> nbits) == '0));

   p_master_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_master |-> (miso_o == 1'b0));

   p_slave_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_master |-> ((mosi_o == 1'b0) && ss_n_o));

   p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode[1] |-> !tx_ready);

endmodule

// File: tb/tb_csspi_port.sv
`timescale 1ns/1ps
module tb_csspi_port;
   localparam int DIV_W = 8;
   localparam int MB    = 32;
   localparam int HB    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          cfg_master = 1'b1;
   logic [1:0]    cfg_mode = 2'b10;
   logic [2:0]    cfg_len = 3'd0;
   logic          cfg_pol = 1'b0;
   logic [7:0]    cfg_half = 8'd2;
   logic [MB-1:0] tx_data = '0;
   logic          tx_valid = 1'b0;
   logic          tx_ready;
   logic [MB-1:0] rx_data;
   logic          rx_valid;
   logic          sck_o, ss_n_o, mosi_o, miso_o, miso_i;
   logic          sck_drv = 1'b0, ss_drv = 1'b1, mosi_drv = 1'b0;
   logic          loop_en = 1'b1;

   assign miso_i = loop_en ? mosi_o : 1'b0;

   csspi_port #(.DIV_W(DIV_W), .MAX_BITS(MB), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_mode(cfg_mode),
      .cfg_len(cfg_len), .cfg_pol(cfg_pol), .cfg_half(cfg_half),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .sck_o(sck_o), .ss_n_o(ss_n_o),
      .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_drv), .ss_n_i(ss_drv),
      .mosi_i(mosi_drv), .miso_o(miso_o)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int nb(input logic [2:0] c);
      case (c)
         3'd1: return 12;
         3'd2: return 16;
         3'd3: return 20;
         3'd4: return 24;
         3'd5: return 32;
         default: return 8;
      endcase
   endfunction

   // Monitor, sampled on the falling edge
   int cyc = 0, tog = 0, t1 = -1, t2 = -1, t_fall = -1, lowcnt = 0;
   int hicnt = 0, last_hi = 0, got_rx = 0;
   logic [MB-1:0] rx_cap = '0;
   logic prev_sck = 1'b0, prev_ss = 1'b1;
   bit pin_bad = 1'b0;
   always @(negedge clk) begin
      cyc++;
      if (sck_o !== prev_sck) begin
         if (tog == 0) t1 = cyc;
         if (tog == 1) t2 = cyc;
         tog++;
      end
      prev_sck = sck_o;
      if (prev_ss && !ss_n_o) begin
         t_fall = cyc;
         last_hi = hicnt;
      end
      if (ss_n_o) hicnt++; else begin hicnt = 0; lowcnt++; end
      prev_ss = ss_n_o;
      if (rx_valid) begin got_rx++; rx_cap = rx_data; end
      if (rst_n && cfg_master && miso_o !== 1'b0) pin_bad = 1'b1;
      if (rst_n && !cfg_master && (mosi_o !== 1'b0 || ss_n_o !== 1'b1)) pin_bad = 1'b1;
   end

   task automatic tk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_mon();
      tog = 0; t1 = -1; t2 = -1; t_fall = -1; lowcnt = 0; got_rx = 0;
   endtask

   task automatic send(input logic [MB-1:0] w);
      bit r;
      tx_data = w;
      tx_valid = 1'b1;
      do begin
         @(negedge clk); r = tx_ready;
         @(posedge clk); #1;
      end while (!r);
      tx_valid = 1'b0;
   endtask

   task automatic wait_rx(input int n);
      int guard = 0;
      while (got_rx < n && guard < 20000) begin tk(1); guard++; end
   endtask

   // {len[77:75], mode[74:73], pol[72], half[71:64], tx[63:32], exp[31:0]}
   localparam logic [77:0] VEC [0:6] = '{
      {3'd0, 2'b10, 1'b0, 8'd2, 32'hDEADBEA5, 32'h000000A5},
      {3'd1, 2'b11, 1'b0, 8'd1, 32'h12345ABC, 32'h00000ABC},
      {3'd2, 2'b10, 1'b1, 8'd3, 32'h0000C3F0, 32'h0000C3F0},
      {3'd3, 2'b11, 1'b1, 8'd2, 32'hFFF9876A, 32'h0009876A},
      {3'd4, 2'b10, 1'b0, 8'd0, 32'h11A5F00F, 32'h00A5F00F},
      {3'd5, 2'b11, 1'b0, 8'd1, 32'h80000001, 32'h80000001},
      {3'd7, 2'b10, 1'b1, 8'd1, 32'h1234567E, 32'h0000007E}
   };

   task automatic slave_xfer(input logic [2:0] len, input logic [1:0] mode, input logic pol,
                             input logic [MB-1:0] mw, input logic [MB-1:0] pre,
                             input bit do_load, input int nsend,
                             output logic [MB-1:0] cap);
      int n;
      logic a;
      n = nb(len);
      cap = '0;
      cfg_master = 1'b0; cfg_mode = mode; cfg_len = len; cfg_pol = pol;
      loop_en = 1'b0; sck_drv = pol; ss_drv = 1'b1; mosi_drv = 1'b0;
      tk(HB);
      if (do_load) send(pre);
      clear_mon();
      ss_drv = 1'b0;
      tk(HB);
      a = mode[0] ? pol : ~pol;
      for (int i = 0; i < nsend; i++) begin
         sck_drv = a;
         mosi_drv = mw[n-1-i];
         tk(HB);
         cap[n-1-i] = miso_o;
         sck_drv = ~a;
         tk(HB);
      end
      sck_drv = pol;
      tk(HB);
      ss_drv = 1'b1;
      tk(HB);
   endtask

   initial begin
      int n, h;
      logic [MB-1:0] cap;
      tk(3);
      // Reset state (R9)
      chk(rx_valid === 1'b0, "R9 reset rx_valid", 32'(rx_valid), 0);
      chk(ss_n_o === 1'b1, "R9 reset ss_n_o", 32'(ss_n_o), 1);
      rst_n = 1'b1;
      tk(2);
      chk(tx_ready === 1'b1, "R9 idle tx_ready", 32'(tx_ready), 1);
      chk(sck_o === cfg_pol, "R3 idle clock level", 32'(sck_o), 32'(cfg_pol));

      // Master vector table with loopback (R1 R2 R3 R5 R6)
      foreach (VEC[k]) begin
         cfg_master = 1'b1; loop_en = 1'b1;
         cfg_len = VEC[k][77:75]; cfg_mode = VEC[k][74:73];
         cfg_pol = VEC[k][72]; cfg_half = VEC[k][71:64];
         n = nb(cfg_len);
         h = (cfg_half == 0) ? 1 : int'(cfg_half);
         tk(2);
         clear_mon();
         send(VEC[k][63:32]);
         wait_rx(1);
         chk(got_rx == 1, "R9 one strobe per packet", 32'(got_rx), 1);
         chk(rx_cap == VEC[k][31:0], "R1 R2 loopback word", rx_cap, VEC[k][31:0]);
         chk(tog == 2 * n, "R3 clock transitions", 32'(tog), 32'(2 * n));
         chk(lowcnt == 2 * n * h, "R3 R6 select low time", 32'(lowcnt), 32'(2 * n * h));
         chk(t2 - t1 == h, "R6 half period", 32'(t2 - t1), 32'(h));
         chk(t1 - t_fall == (cfg_mode[0] ? h : 0), "R5 first edge offset",
             32'(t1 - t_fall), 32'(cfg_mode[0] ? h : 0));
         tk(4 * h + 4);
      end
      chk(!pin_bad, "R7 master idle pin", 32'(pin_bad), 0);

      // Back-to-back words (R4)
      cfg_len = 3'd0; cfg_mode = 2'b10; cfg_pol = 1'b0; cfg_half = 8'd2;
      tk(2);
      clear_mon();
      tx_data = 32'h0000005A;
      tx_valid = 1'b1;
      wait_rx(1);
      tk(1);
      chk(tx_ready === 1'b0, "R4 no ready in gap", 32'(tx_ready), 0);
      chk(ss_n_o === 1'b1, "R4 select high after packet", 32'(ss_n_o), 1);
      wait_rx(2);
      tx_valid = 1'b0;
      chk(got_rx == 2, "R4 two packets", 32'(got_rx), 2);
      chk(last_hi >= 8, "R4 deselect gap", 32'(last_hi), 8);
      chk(rx_cap == 32'h5A, "R4 second word", rx_cap, 32'h5A);
      tk(16);

      // Disabled mode (R5)
      cfg_mode = 2'b01;
      clear_mon();
      tx_valid = 1'b1;
      tk(1);
      chk(tx_ready === 1'b0, "R5 disabled ready", 32'(tx_ready), 0);
      tk(30);
      chk(lowcnt == 0 && got_rx == 0, "R5 disabled no packet", 32'(lowcnt + got_rx), 0);
      tx_valid = 1'b0;
      cfg_mode = 2'b10;
      tk(2);

      // Slave role (R7 R8 R10 R2)
      pin_bad = 1'b0;
      slave_xfer(3'd2, 2'b10, 1'b0, 32'h0000BEEF, 32'h00001234, 1'b1, 16, cap);
      chk(got_rx == 1 && rx_cap == 32'hBEEF, "R7 slave receive no-delay", rx_cap, 32'hBEEF);
      chk(cap == 32'h1234, "R8 slave send preload", cap, 32'h1234);

      slave_xfer(3'd1, 2'b11, 1'b1, 32'h000005A5, 32'hABCDEFC3, 1'b1, 12, cap);
      chk(got_rx == 1 && rx_cap == 32'h5A5, "R5 slave receive delay", rx_cap, 32'h5A5);
      chk(cap == 32'hFC3, "R2 upper tx bits ignored", cap, 32'hFC3);

      slave_xfer(3'd0, 2'b11, 1'b0, 32'h0000003C, 32'hFFFFFFFF, 1'b0, 8, cap);
      chk(cap == 32'h0, "R8 zeros when nothing loaded", cap, 0);
      chk(rx_cap == 32'h3C, "R8 receive while unloaded", rx_cap, 32'h3C);

      slave_xfer(3'd0, 2'b10, 1'b0, 32'h000000FF, 32'h000000AA, 1'b1, 3, cap);
      chk(got_rx == 0, "R10 abort gives no strobe", 32'(got_rx), 0);

      slave_xfer(3'd5, 2'b10, 1'b1, 32'hCAFEF00D, 32'h13579BDF, 1'b1, 32, cap);
      chk(got_rx == 1 && rx_cap == 32'hCAFEF00D, "R10 packet after abort", rx_cap, 32'hCAFEF00D);
      chk(cap == 32'h13579BDF, "R1 slave 32-bit send", cap, 32'h13579BDF);
      chk(!pin_bad, "R7 slave pins quiet", 32'(pin_bad), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule